// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Bypass and Matched Fanout

This block takes one input clock and drives a small bank of identical clock outputs. Each output carries either the input clock itself or the input clock divided by 2, 4, 8 or 16. A 2-bit ratio code picks the division. A separate bypass select steers the output multiplexer between the undivided clock and the divided clock. Every output is driven from the single selected signal, so the copies stay matched.

An output enable is captured on the falling edge of the input clock before it gates anything. As a result, enabling or disabling the outputs never cuts a pulse short. A divided high level that is already in progress always runs to its end. An active-low asynchronous reset clears the divider phase and the enable, and holds every output low.

A change of the ratio code restarts the phase count without toggling the output. The level present at that moment therefore lasts at least one half-period of the newly selected ratio.

Top module: `clk_ratio_fanout`

## Requirements
- R1: While `rst_ni` is low, every bit of `clk_o` is low, and the divider phase and the captured enable are cleared.
- R2: With the ratio code steady, code 0, 1, 2 and 3 give division ratios N of 2, 4, 8 and 16. In steady state the divided output is high for N/2 input cycles and low for N/2 input cycles, and it changes only at rising input edges.
- R3: After reset is released, with the enable high, bypass at 0 and the code steady, the divided output first goes high at the (N/2)-th rising input edge.
- R4: With `bypass_i` = 1, the outputs equal the input clock ANDed with the captured enable. With `bypass_i` = 0, the outputs carry the divided clock. The select acts at once, without waiting for a clock edge.
- R5: `out_en_i` is captured at every falling input edge. A low capture holds the bypass output low from the next rising edge onward. A divided high level already in progress completes its full half-period, and no new divided high level begins.
- R6: Toggle points of the divided clock keep coming every N/2 rising edges while the output is disabled. The divided output goes high at the first toggle point at which the captured enable is high.
- R7: A new ratio code is seen at the next rising edge. At that edge the output keeps its level and the phase count restarts, so the next toggle comes N_new/2 rising edges later. No divided level is ever shorter than N_new/2 input cycles.
- R8: All bits of `clk_o` carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, both to be divided and to be passed through |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 2 | Ratio code: N = 2^(code+1) |
| bypass_i | input | 1 | 1 selects the undivided clock, 0 selects the divided clock |
| out_en_i | input | 1 | Output enable, captured on falling input edges |
| clk_o | output | 2 | Matched clock outputs |

## Verification
The code, the bypass select and reset take effect at the first rising edge after they are driven. A change of `out_en_i` shows up only one cycle later, because it first has to pass the falling-edge capture and then reach a rising edge. The bench drives all inputs 7 ns after a falling edge and queues the expected values for the cycle that follows. It then samples the outputs 5 ns after the rising edge, while the input clock is high, and 5 ns after the falling edge, while it is low. This two-point sampling tells a passed-through clock apart from a steady divided level. The expected divided patterns are worked out per scenario from the toggle points that R2, R6 and R7 set.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   // Output path chosen by the bypass select
   typedef enum logic {
      PATH_DIV = 1'b0,
      PATH_BYP = 1'b1
   } path_e;

   // Number of input cycles in one half-period of the divided clock
   function automatic int unsigned half_of(input int unsigned code);
      return 32'd1 << code;
   endfunction

   // Counter width able to hold the largest half-period minus one
   function automatic int phase_width(input int code_w);
      return (1 << code_w) - 1;
   endfunction

endpackage

// File: rtl/cdiv_en_flop.sv
module cdiv_en_flop (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic en_q_o
);

   // Captured on the falling edge so that gating changes while the clock is low
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q_o <= 1'b0;
      else         en_q_o <= en_i;
   end

endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen #(
   parameter int CODE_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              en_i,
   output logic              div_o
);

   localparam int CNT_W = cdiv_pkg::phase_width(CODE_W);
   localparam int RUN_W = CNT_W + 1;

   logic [CODE_W-1:0] code_q;
   logic              primed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  limit;
   logic              div_q;
   logic              code_moved;
   logic              at_edge;
   logic [RUN_W-1:0]  run_q;

   // Last count of a half-period: half length minus one, taken from the live code
   always_comb begin
      limit      = {CNT_W{1'b1}} >> (CNT_W - int'(code_i));
      code_moved = primed_q && (code_i != code_q);
      at_edge    = !code_moved && (cnt_q == limit);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q   <= '0;
         primed_q <= 1'b0;
         cnt_q    <= '0;
         div_q    <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         code_q   <= code_i;
         if (code_moved) begin
            cnt_q <= '0;                 // restart the phase, keep the level
         end else if (at_edge) begin
            cnt_q <= '0;
            if (div_q) div_q <= 1'b0;     // a high level always ends on time
            else       div_q <= en_i;     // a new high level needs the enable
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign div_o = div_q;

   // Length of the level in progress, kept for the pulse-width check
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    run_q <= '0;
      else if (div_q != div_o_next()) run_q <= '0;
      else if (run_q != '1)           run_q <= run_q + RUN_W'(1);
   end

   function automatic logic div_o_next();
      if (code_moved || !at_edge) return div_q;
      return div_q ? 1'b0 : en_i;
   endfunction

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> (int'(cnt_q) < int'(cdiv_pkg::half_of(32'(code_q)))))
      else $error("phase count beyond half-period");   // R2

   AST_RISE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_q) |-> $past(en_i))
      else $error("divided high began while disabled");   // R5

   AST_MIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q != $past(div_q)) |->
         (int'($past(run_q)) + 1 >= int'(cdiv_pkg::half_of(32'(code_q)))))
      else $error("divided level shorter than half-period");   // R7

endmodule

// File: rtl/cdiv_out_stage.sv
module cdiv_out_stage #(
   parameter int N_OUTS = 2
) (
   input  logic              clk_i,
   input  logic              en_i,
   input  logic              byp_i,
   input  logic              div_i,
   output logic [N_OUTS-1:0] clk_o
);

   logic pick;

   always_comb begin
      if (cdiv_pkg::path_e'(byp_i) == cdiv_pkg::PATH_BYP) pick = clk_i & en_i;
      else                                                pick = div_i;
   end

   // Every copy comes from the one selected net
   for (genvar g = 0; g < N_OUTS; g++) begin : g_fan
      assign clk_o[g] = pick;
   end

endmodule

// File: rtl/clk_ratio_fanout.sv
module clk_ratio_fanout #(
   parameter int CODE_W = 2,
   parameter int N_OUTS = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] ratio_sel_i,
   input  logic              bypass_i,
   input  logic              out_en_i,
   output logic [N_OUTS-1:0] clk_o
);

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
      $error("CODE_W must lie in 1..4");
   end
   if (N_OUTS < 1) begin : g_bad_outs
      $error("N_OUTS must be at least 1");
   end

   logic en_q;
   logic div_clk;

   cdiv_en_flop u_en (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (out_en_i),
      .en_q_o (en_q)
   );

   cdiv_phase_gen #(.CODE_W(CODE_W)) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (ratio_sel_i),
      .en_i   (en_q),
      .div_o  (div_clk)
   );

   cdiv_out_stage #(.N_OUTS(N_OUTS)) u_out (
      .clk_i (clk_i),
      .en_i  (en_q),
      .byp_i (bypass_i),
      .div_i (div_clk),
      .clk_o (clk_o)
   );

   AST_RST_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (clk_o == '0))
      else $error("output active during reset");   // R1

endmodule

// File: tb/sim_clk_ratio_fanout.sv
module sim_clk_ratio_fanout;

   typedef struct {
      logic  hi;
      logic  lo;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] code_r = 2'd0;
   logic       byp_r = 1'b0;
   logic       en_r = 1'b0;
   logic [1:0] clk_o;

   int   vectors = 0;
   int   miscompares = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   clk_ratio_fanout u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ratio_sel_i (code_r),
      .bypass_i    (byp_r),
      .out_en_i    (en_r),
      .clk_o       (clk_o)
   );

   task automatic check(input logic exp, input string req, input string when);
      vectors++;
      if (clk_o[0] !== exp || clk_o[1] !== exp) begin
         miscompares++;
         $display("FAIL %s (%s sample @%0t): clk_o=%b expected %b%b", req, when, $time, clk_o, exp, exp);
      end
      vectors++;
      if (clk_o[0] !== clk_o[1]) begin
         miscompares++;
         $display("FAIL R8 (%s sample @%0t): clk_o[0]=%b clk_o[1]=%b expected equal", when, $time, clk_o[0], clk_o[1]);
      end
   endtask

   // Monitor: one queued item per cycle, sampled with clock high then low
   always @(posedge clk) begin
      exp_t cur;
      bit   have;
      #5;
      have = (sb.size() > 0);
      if (have) begin
         cur = sb.pop_front();
         check(cur.hi, cur.req, "high");
      end
      #10;
      if (have) check(cur.lo, cur.req, "low");
   end

   // Driver slot: 7 ns after a falling edge; inputs set here act on the next cycle
   task automatic slot();
      @(negedge clk);
      #7;
   endtask

   task automatic push(input logic h, input logic l, input string r);
      sb.push_back('{h, l, r});
   endtask

   task automatic do_reset(input logic [1:0] code, input logic byp, input logic en);
      slot();
      rst_n  = 1'b0;
      code_r = code;
      byp_r  = byp;
      en_r   = en;
      push(1'b0, 1'b0, "R1");
      for (int i = 0; i < 3; i++) begin
         slot();
         push(1'b0, 1'b0, "R1");
      end
      @(posedge clk);
      #3;
      rst_n = 1'b1;
   endtask

   initial begin
      // R2 / R3: every ratio from reset, enable high, divided path
      for (int m = 0; m < 4; m++) begin
         int h;
         h = 1 << m;
         do_reset(2'(m), 1'b0, 1'b1);
         for (int e = 1; e <= 4 * h; e++) begin
            logic v;
            slot();
            v = logic'((e / h) % 2);
            push(v, v, (e <= h) ? "R3" : "R2");
         end
      end

      // R4 / R5: bypass, enable drop and return, then switch to divided (code 0)
      do_reset(2'd0, 1'b1, 1'b1);
      for (int e = 1; e <= 18; e++) begin
         logic v;
         slot();
         if (e == 7)  en_r  = 1'b0;
         if (e == 11) en_r  = 1'b1;
         if (e == 14) byp_r = 1'b0;
         if (e <= 7)        push(1'b1, 1'b0, "R4");
         else if (e <= 11)  push(1'b0, 1'b0, "R5");
         else if (e <= 13)  push(1'b1, 1'b0, "R5");
         else begin
            v = logic'((e + 1) % 2);
            push(v, v, "R4");
         end
      end

      // R5 / R6: divided by 4, disable while high, re-enable later
      do_reset(2'd1, 1'b0, 1'b1);
      begin
         logic [11:0] pat;
         pat = 12'b1001_1000_0110;   // bit e-1 holds the level after edge e
         for (int e = 1; e <= 12; e++) begin
            slot();
            if (e == 3) en_r = 1'b0;
            if (e == 7) en_r = 1'b1;
            push(pat[e-1], pat[e-1], (e <= 7) ? "R5" : "R6");
         end
      end

      // R7: ratio raised from /2 to /16 while high
      do_reset(2'd0, 1'b0, 1'b1);
      for (int e = 1; e <= 22; e++) begin
         logic v;
         slot();
         if (e == 6) code_r = 2'd3;
         if (e < 6) v = logic'(e % 2);
         else       v = logic'(1 ^ (((e - 6) / 8) & 1));
         push(v, v, "R7");
      end

      // R7: ratio lowered from /16 to /2 while high
      do_reset(2'd3, 1'b0, 1'b1);
      for (int e = 1; e <= 20; e++) begin
         logic v;
         slot();
         if (e == 12) code_r = 2'd0;
         if (e < 12) v = logic'((e / 8) % 2);
         else        v = logic'(1 ^ ((e - 12) & 1));
         push(v, v, "R7");
      end

      // R1: reset again at the end, outputs must fall and stay low
      do_reset(2'd2, 1'b0, 1'b1);
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule